// File: doc/BRIEF.md
# Card Slot Contact Power Sequencer

This block runs the contact power sequence of one smart-card slot. The host raises a session request, and the block turns on the contacts one at a time, in a fixed order, with the same number of clock cycles between steps. First it requests the shared step-up converter. Then it enables card VCC, releases the I/O and auxiliary lines to receive, starts the card clock, and finally releases the card reset after a programmable number of cycles. When the host withdraws the request, the block switches the contacts off in the reverse, power-safe order. It then drops its converter request and returns to the clamped idle state.

The block watches card presence, the supply supervisor, overcurrent and overheat at all times. If any of these trips during a session, the block clears the session bit itself and starts the same orderly shutdown. It records each event in a sticky flag, and a read strobe from the host clears the flags. An active-low interrupt stays asserted while any flag is set. The converter is shared with a second slot, so its enable stays on while that other slot reports activity.

Top module: `scs_contact_seq`

## Requirements
- R1: After reset all contact outputs, the session bit, the slot-active output, the converter enable and every flag are 0, the clamp output is 1 and the interrupt output is 1.
- R2: A session request is taken only in idle, and only when the supply is good, the card is present, overcurrent and overheat are low, and flags[1], flags[2] and flags[3] are all 0. A request refused for any of these reasons leaves every output unchanged.
- R3: On an accepted request, session bit, slot-active and converter enable rise and clamp falls one cycle later. VCC rises STEP cycles after that, the I/O/C4/C8 release follows STEP cycles later, and the card clock starts STEP cycles after the release.
- R4: Card reset rises H cycles after the card clock starts, where H is the hold input; a hold value of 0 acts as 1.
- R5: A host clear during a session drops the session bit and card reset one cycle later. The card clock stops STEP cycles after that, the lines are pulled low STEP cycles after that, VCC falls STEP cycles later, and STEP cycles after VCC the slot returns to idle. An output that was never raised does not move.
- R6: The converter enable is 1 while this slot is not idle or while the peer-slot input is 1, one cycle after either changes.
- R7: Card removal, a supply fall, overcurrent or overheat during a session clears the session bit in hardware one cycle later and runs the R5 shutdown.
- R8: Flags are sticky. flags[0] is set by any presence change, flags[1] by a falling supply-good input, flags[2] by overcurrent while not idle, and flags[3] by overheat while not idle. Each is set one cycle after its event.
- R9: The interrupt output is 0 exactly while any flag is 1.
- R10: A status-read strobe clears all flags one cycle later. An event in the same cycle as the read still leaves its flag set.
- R11: A session request made while a shutdown is running is ignored.
- R12: The clamp output is 1 only in idle, and then VCC, lines, clock and reset are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_set_i | input | 1 | Host request to begin a session (pulse) |
| start_clr_i | input | 1 | Host request to end the session (pulse) |
| hold_cyc_i | input | HOLD_W | Card clock cycles before reset release |
| card_present_i | input | 1 | Card presence switch, 1 = inserted |
| supply_ok_i | input | 1 | Supply supervisor, 1 = supply good |
| overcurrent_i | input | 1 | Contact overload detector |
| overheat_i | input | 1 | Overtemperature detector |
| peer_active_i | input | 1 | Other slot needs the converter |
| status_rd_i | input | 1 | Status read strobe, clears flags |
| start_o | output | 1 | Session bit |
| slot_active_o | output | 1 | This slot needs the converter |
| boost_en_o | output | 1 | Step-up converter enable |
| vcc_en_o | output | 1 | Card VCC enable |
| lines_rel_o | output | 1 | I/O, C4, C8 released (0 = driven low) |
| clk_en_o | output | 1 | Card clock gate |
| card_rst_o | output | 1 | Card reset line level |
| clamp_o | output | 1 | Contacts held low-impedance to ground |
| irq_n_o | output | 1 | Active-low interrupt |
| flags_o | output | 4 | Sticky event flags |

## Verification
The hardest situation to reach from the ports is a fault that lands partway through power-up. In that case some contacts are already on and others were never raised, and the shutdown has to walk its full schedule while moving only the outputs that were on. The stimulus raises overcurrent for a single cycle while VCC is up but before the lines are released. It then expects exactly one VCC fall and one return to idle, at their scheduled cycles, and nothing else. A second hard case is a flag event that lands in the same cycle as a status read. The stimulus drops the supply in exactly the cycle the read strobe is high, and expects the supply flag to survive the read.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_UP_BOOST, ST_UP_VCC, ST_UP_LINES, ST_UP_CLK, ST_ON,
    ST_DN_RST, ST_DN_CLK, ST_DN_LINES, ST_DN_VCC
  } seq_state_e;

  localparam int FLG_PRES   = 0;
  localparam int FLG_SUPPLY = 1;
  localparam int FLG_OVC    = 2;
  localparam int FLG_HEAT   = 3;
  localparam int FLG_N      = 4;

  typedef struct packed {
    logic vcc;
    logic lines;
    logic clk;
    logic rst;
  } contact_t;
endpackage

// File: rtl/scs_step_timer.sv
module scs_step_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] lim,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + 1'b1;
  end

  a_r4_count_restarts: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/scs_fault_latch.sv
module scs_fault_latch
  import scs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             card_present_i,
  input  logic             supply_ok_i,
  input  logic             overcurrent_i,
  input  logic             overheat_i,
  input  logic             powered_i,
  input  logic             status_rd_i,
  output logic [FLG_N-1:0] flags_o,
  output logic             prot_o,
  output logic             irq_n_o
);
  logic             pres_prev_q, sup_prev_q;
  logic [FLG_N-1:0] ev, flags_d;

  always_comb begin
    ev             = '0;
    ev[FLG_PRES]   = card_present_i ^ pres_prev_q;
    ev[FLG_SUPPLY] = sup_prev_q & ~supply_ok_i;
    ev[FLG_OVC]    = overcurrent_i & powered_i;
    ev[FLG_HEAT]   = overheat_i & powered_i;
    flags_d        = (flags_o & {FLG_N{~status_rd_i}}) | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_prev_q <= 1'b0;
      sup_prev_q  <= 1'b1;
      flags_o     <= '0;
      irq_n_o     <= 1'b1;
    end else begin
      pres_prev_q <= card_present_i;
      sup_prev_q  <= supply_ok_i;
      flags_o     <= flags_d;
      irq_n_o     <= ~|flags_d;
    end
  end

  assign prot_o = flags_o[FLG_SUPPLY] | flags_o[FLG_OVC] | flags_o[FLG_HEAT];

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !status_rd_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == (flags_o == '0));
  a_r10_supply_kept: assert property (@(posedge clk) disable iff (rst)
    (status_rd_i && sup_prev_q && !supply_ok_i) |=> flags_o[FLG_SUPPLY]);
endmodule

// File: rtl/scs_seq_fsm.sv
module scs_seq_fsm
  import scs_pkg::*;
#(
  parameter int STEP_CYCLES = 8,
  parameter int HOLD_W      = 16,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_set_i,
  input  logic              start_clr_i,
  input  logic [HOLD_W-1:0] hold_cyc_i,
  input  logic              card_present_i,
  input  logic              supply_ok_i,
  input  logic              overcurrent_i,
  input  logic              overheat_i,
  input  logic              prot_flag_i,
  input  logic              peer_active_i,
  input  logic              step_done_i,
  output logic              restart_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic              powered_o,
  output logic              start_o,
  output logic              slot_active_o,
  output logic              boost_en_o,
  output contact_t          con_o,
  output logic              clamp_o
);
  seq_state_e        state_q, state_d;
  contact_t          con_d;
  logic              allow, emerg, kill, start_d;
  logic [HOLD_W-1:0] hold_eff;

  assign allow = supply_ok_i & card_present_i & ~overcurrent_i & ~overheat_i & ~prot_flag_i;
  assign emerg = ~card_present_i | ~supply_ok_i | overcurrent_i | overheat_i;
  assign kill  = start_clr_i | emerg;

  assign hold_eff = (hold_cyc_i == '0) ? HOLD_W'(1) : hold_cyc_i;
  assign lim_o    = (state_q == ST_UP_CLK) ? (CNT_W'(hold_eff) - CNT_W'(1))
                                           : CNT_W'(STEP_CYCLES - 1);
  assign powered_o = (state_q != ST_IDLE);
  assign restart_o = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    start_d = start_o;
    unique case (state_q)
      ST_IDLE: if (start_set_i && allow) begin
        state_d = ST_UP_BOOST;
        start_d = 1'b1;
      end
      ST_UP_BOOST, ST_UP_VCC, ST_UP_LINES, ST_UP_CLK, ST_ON: begin
        if (kill) begin
          state_d = ST_DN_RST;
          start_d = 1'b0;
        end else if (step_done_i) begin
          unique case (state_q)
            ST_UP_BOOST: state_d = ST_UP_VCC;
            ST_UP_VCC:   state_d = ST_UP_LINES;
            ST_UP_LINES: state_d = ST_UP_CLK;
            ST_UP_CLK:   state_d = ST_ON;
            default:     state_d = ST_ON;
          endcase
        end
      end
      ST_DN_RST:   if (step_done_i) state_d = ST_DN_CLK;
      ST_DN_CLK:   if (step_done_i) state_d = ST_DN_LINES;
      ST_DN_LINES: if (step_done_i) state_d = ST_DN_VCC;
      ST_DN_VCC:   if (step_done_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    con_d = con_o;
    unique case (state_d)
      ST_UP_VCC:   con_d = contact_t'(4'b1000);
      ST_UP_LINES: con_d = contact_t'(4'b1100);
      ST_UP_CLK:   con_d = contact_t'(4'b1110);
      ST_ON:       con_d = contact_t'(4'b1111);
      ST_DN_RST:   con_d.rst = 1'b0;
      ST_DN_CLK:   begin con_d.rst = 1'b0; con_d.clk = 1'b0; end
      ST_DN_LINES: begin con_d.rst = 1'b0; con_d.clk = 1'b0; con_d.lines = 1'b0; end
      default:     con_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      start_o       <= 1'b0;
      con_o         <= '0;
      slot_active_o <= 1'b0;
      boost_en_o    <= 1'b0;
      clamp_o       <= 1'b1;
    end else begin
      state_q       <= state_d;
      start_o       <= start_d;
      con_o         <= con_d;
      slot_active_o <= (state_d != ST_IDLE);
      boost_en_o    <= (state_d != ST_IDLE) | peer_active_i;
      clamp_o       <= (state_d == ST_IDLE);
    end
  end

  a_r2_gate_supply: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !supply_ok_i) |=> (state_q == ST_IDLE));
  a_r7_removal_clears: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && !card_present_i) |=> !start_o);
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {ST_DN_RST, ST_DN_CLK, ST_DN_LINES, ST_DN_VCC} && start_set_i) |=> !start_o);
  a_r3_clk_after_lines: assert property (@(posedge clk) disable iff (rst)
    con_o.clk |-> con_o.lines);
  a_r3_lines_after_vcc: assert property (@(posedge clk) disable iff (rst)
    con_o.lines |-> con_o.vcc);
  a_r5_rst_before_clk: assert property (@(posedge clk) disable iff (rst)
    con_o.rst |-> con_o.clk);
  a_r6_vcc_needs_boost: assert property (@(posedge clk) disable iff (rst)
    con_o.vcc |-> boost_en_o);
  a_r12_clamp_quiet: assert property (@(posedge clk) disable iff (rst)
    clamp_o |-> (con_o == '0));
endmodule

// File: rtl/scs_contact_seq.sv
module scs_contact_seq
  import scs_pkg::*;
#(
  parameter int STEP_CYCLES = 8,
  parameter int HOLD_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_set_i,
  input  logic              start_clr_i,
  input  logic [HOLD_W-1:0] hold_cyc_i,
  input  logic              card_present_i,
  input  logic              supply_ok_i,
  input  logic              overcurrent_i,
  input  logic              overheat_i,
  input  logic              peer_active_i,
  input  logic              status_rd_i,
  output logic              start_o,
  output logic              slot_active_o,
  output logic              boost_en_o,
  output logic              vcc_en_o,
  output logic              lines_rel_o,
  output logic              clk_en_o,
  output logic              card_rst_o,
  output logic              clamp_o,
  output logic              irq_n_o,
  output logic [3:0]        flags_o
);
  localparam int STEP_W = $clog2(STEP_CYCLES) + 1;
  localparam int CNT_W  = (HOLD_W > STEP_W) ? HOLD_W : STEP_W;

  logic             restart, step_done, powered, prot;
  logic [CNT_W-1:0] lim;
  contact_t         con;
  logic [FLG_N-1:0] flags;

  scs_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .lim(lim), .done(step_done)
  );

  scs_fault_latch u_faults (
    .clk(clk), .rst(rst),
    .card_present_i(card_present_i), .supply_ok_i(supply_ok_i),
    .overcurrent_i(overcurrent_i), .overheat_i(overheat_i),
    .powered_i(powered), .status_rd_i(status_rd_i),
    .flags_o(flags), .prot_o(prot), .irq_n_o(irq_n_o)
  );

  scs_seq_fsm #(.STEP_CYCLES(STEP_CYCLES), .HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst),
    .start_set_i(start_set_i), .start_clr_i(start_clr_i), .hold_cyc_i(hold_cyc_i),
    .card_present_i(card_present_i), .supply_ok_i(supply_ok_i),
    .overcurrent_i(overcurrent_i), .overheat_i(overheat_i),
    .prot_flag_i(prot), .peer_active_i(peer_active_i), .step_done_i(step_done),
    .restart_o(restart), .lim_o(lim), .powered_o(powered),
    .start_o(start_o), .slot_active_o(slot_active_o), .boost_en_o(boost_en_o),
    .con_o(con), .clamp_o(clamp_o)
  );

  assign vcc_en_o    = con.vcc;
  assign lines_rel_o = con.lines;
  assign clk_en_o    = con.clk;
  assign card_rst_o  = con.rst;
  assign flags_o     = flags;

  a_r6_peer_holds_boost: assert property (@(posedge clk) disable iff (rst)
    peer_active_i |=> boost_en_o);
endmodule

// File: tb/sim_scs_contact_seq.sv
module sim_scs_contact_seq;
  localparam int S  = 8;
  localparam int HW = 16;
  localparam int B_START = 12, B_ACT = 11, B_BOOST = 10, B_VCC = 9, B_LINES = 8,
                 B_CLK = 7, B_RST = 6, B_CLAMP = 5, B_IRQN = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic start_set = 0, start_clr = 0, present = 0, supply = 1, ovc = 0, heat = 0;
  logic peer = 0, rd = 0;
  logic [HW-1:0] hold = 20;
  logic start_o, act_o, boost_o, vcc_o, lines_o, clk_en_o, rst_o, clamp_o, irq_n_o;
  logic [3:0] flags_o;

  scs_contact_seq #(.STEP_CYCLES(S), .HOLD_W(HW)) u0 (
    .clk(clk), .rst(rst), .start_set_i(start_set), .start_clr_i(start_clr),
    .hold_cyc_i(hold), .card_present_i(present), .supply_ok_i(supply),
    .overcurrent_i(ovc), .overheat_i(heat), .peer_active_i(peer), .status_rd_i(rd),
    .start_o(start_o), .slot_active_o(act_o), .boost_en_o(boost_o), .vcc_en_o(vcc_o),
    .lines_rel_o(lines_o), .clk_en_o(clk_en_o), .card_rst_o(rst_o), .clamp_o(clamp_o),
    .irq_n_o(irq_n_o), .flags_o(flags_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int q_cyc[$];
  logic [12:0] q_v[$];
  string q_tag[$];
  logic [12:0] m;
  logic [12:0] last;
  bit mon_on = 0;

  function automatic logic [12:0] snap();
    return {start_o, act_o, boost_o, vcc_o, lines_o, clk_en_o, rst_o, clamp_o, irq_n_o, flags_o};
  endfunction

  task automatic push(int c, string tag);
    q_cyc.push_back(c); q_v.push_back(m); q_tag.push_back(tag);
  endtask

  task automatic chk(string tag, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every change of the output vector must match the next expected item
  always @(negedge clk) begin : mon
    logic [12:0] v;
    int ec;
    logic [12:0] evv;
    string et;
    if (mon_on) begin
      v = snap();
      if (v !== last) begin
        checks++;
        if (q_cyc.size() == 0) begin
          errors++;
          $display("FAIL unexpected change at cycle %0d actual %b expected %b", cyc, v, last);
        end else begin
          ec = q_cyc.pop_front(); evv = q_v.pop_front(); et = q_tag.pop_front();
          if (ec != cyc || evv !== v) begin
            errors++;
            $display("FAIL %s actual cycle %0d %b expected cycle %0d %b", et, cyc, v, ec, evv);
          end
        end
        last = v;
      end
    end
  end

  // full activation; events follow R3 and R4
  task automatic activate(int h);
    int n, he;
    he = (h == 0) ? 1 : h;
    hold = HW'(h);
    n = cyc;
    start_set = 1;
    m[B_START] = 1; m[B_ACT] = 1; m[B_BOOST] = 1; m[B_CLAMP] = 0; push(n + 1, "R3 start");
    m[B_VCC] = 1;   push(n + 1 + S, "R3 vcc");
    m[B_LINES] = 1; push(n + 1 + 2*S, "R3 lines");
    m[B_CLK] = 1;   push(n + 1 + 3*S, "R3 clk");
    m[B_RST] = 1;   push(n + 1 + 3*S + he, "R4 rst");
    tick(1);
    start_set = 0;
    tick(3*S + he + 2);
  endtask

  // shutdown steps after the first cycle at n+1 (R5)
  task automatic deact_tail(int n);
    if (m[B_CLK])   begin m[B_CLK] = 0;   push(n + 1 + S, "R5 clk"); end
    if (m[B_LINES]) begin m[B_LINES] = 0; push(n + 1 + 2*S, "R5 lines"); end
    if (m[B_VCC])   begin m[B_VCC] = 0;   push(n + 1 + 3*S, "R5 vcc"); end
    m[B_ACT] = 0; m[B_BOOST] = peer; m[B_CLAMP] = 1; push(n + 1 + 4*S, "R5 idle");
  endtask

  task automatic read_clear(string tag);
    int n;
    n = cyc;
    rd = 1;
    m[3:0] = 4'b0; m[B_IRQN] = 1; push(n + 1, tag);
    tick(1);
    rd = 0;
    tick(2);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin : main
    int n;
    tick(4);
    chk("R1 reset state", snap(), 13'b0_0_0_0_0_0_0_1_1_0000);
    rst = 0;
    last = snap(); m = last; mon_on = 1;
    tick(3);

    // R8 / R9: insertion sets flags[0] and drops the interrupt
    n = cyc; present = 1;
    m[0] = 1; m[B_IRQN] = 0; push(n + 1, "R8 insert");
    tick(3);
    read_clear("R10 read clears presence");

    // R3 / R4 full activation, then R5 host clear with R11 request mid-shutdown
    activate(20);
    n = cyc; start_clr = 1;
    m[B_START] = 0; m[B_RST] = 0; push(n + 1, "R5 rst");
    deact_tail(n);
    tick(1); start_clr = 0;
    tick(4); start_set = 1; tick(1); start_set = 0;
    tick(1);
    chk("R11 request ignored in shutdown", {12'b0, start_o}, 13'b0);
    tick(4*S);
    chk("R12 idle clamp", {9'b0, clamp_o, vcc_o, clk_en_o, rst_o}, 13'b1000);

    // R6 peer sharing, with R4 hold of zero
    n = cyc; peer = 1;
    m[B_BOOST] = 1; push(n + 1, "R6 peer on");
    tick(3);
    activate(0);
    n = cyc; start_clr = 1;
    m[B_START] = 0; m[B_RST] = 0; push(n + 1, "R5 rst");
    deact_tail(n);
    tick(1); start_clr = 0;
    tick(4*S + 3);
    n = cyc; peer = 0;
    m[B_BOOST] = 0; push(n + 1, "R6 peer off");
    tick(3);

    // R7 card removal in session
    activate(20);
    n = cyc; present = 0;
    m[B_START] = 0; m[B_RST] = 0; m[0] = 1; m[B_IRQN] = 0; push(n + 1, "R7 removal");
    deact_tail(n);
    tick(4*S + 3);
    start_set = 1; tick(1); start_set = 0; tick(2);
    chk("R2 no card refused", {12'b0, start_o}, 13'b0);
    present = 1;
    tick(2);
    read_clear("R10 read after removal");

    // R7 / R8 overcurrent while VCC is up but lines are not released
    n = cyc; hold = 20; start_set = 1;
    m[B_START] = 1; m[B_ACT] = 1; m[B_BOOST] = 1; m[B_CLAMP] = 0; push(n + 1, "R3 start");
    m[B_VCC] = 1; push(n + 1 + S, "R3 vcc");
    tick(1); start_set = 0;
    tick(S + 2);
    n = cyc; ovc = 1;
    m[B_START] = 0; m[2] = 1; m[B_IRQN] = 0; push(n + 1, "R7 overcurrent");
    deact_tail(n);
    tick(1); ovc = 0;
    tick(4*S + 3);
    start_set = 1; tick(1); start_set = 0; tick(2);
    chk("R2 pending fault refused", {12'b0, start_o}, 13'b0);
    read_clear("R10 read after overcurrent");

    // R10 supply fall in the same cycle as a read
    n = cyc; supply = 0; rd = 1;
    m[1] = 1; m[B_IRQN] = 0; push(n + 1, "R10 event beats read");
    tick(1); rd = 0;
    tick(2);
    start_set = 1; tick(1); start_set = 0; tick(2);
    chk("R2 supply low refused", {12'b0, start_o}, 13'b0);
    supply = 1;
    tick(2);
    read_clear("R10 read supply flag");

    // R7 overheat in session
    activate(5);
    n = cyc; heat = 1;
    m[B_START] = 0; m[B_RST] = 0; m[3] = 1; m[B_IRQN] = 0; push(n + 1, "R7 overheat");
    deact_tail(n);
    tick(1); heat = 0;
    tick(4*S + 3);
    chk("R9 irq low with flag", {12'b0, irq_n_o}, 13'b0);
    read_clear("R10 read overheat");

    tick(5);
    while (q_cyc.size() != 0) begin
      checks++; errors++;
      $display("FAIL %s actual none expected at cycle %0d", q_tag[0], q_cyc[0]);
      void'(q_cyc.pop_front()); void'(q_v.pop_front()); void'(q_tag.pop_front());
    end
    summary();
    $finish;
  end
endmodule